// File: doc/BRIEF.md
# Pipe Buffer-Ready Interrupt Controller

This block raises buffer-ready interrupts for the endpoint pipes of a USB host/function pipe engine. It sits between the packet transfer engine and the CPU-side FIFO port. Each pipe keeps a sticky pending flag, which feeds a combined interrupt line, and a receive-enable output that the transfer engine must sample before it accepts a packet into that pipe's FIFO.

Each pipe has a one-bit mode. With the mode clear, a pipe flags ready as soon as a packet finishes on the bus, in either direction. With the mode set, a receiving pipe waits until the CPU has read the last word of the packet out of the FIFO. It then flags ready and closes reception until software issues a buffer clear. A transmitting pipe in that mode never flags ready. Only a middle range of pipes honours the mode. A mode write is accepted only while the pipe is idle and is not selected on the CPU port. An auto-clear strobe flushes a pipe's interrupt, read-wait and lock state.

Top module: `brdy_irq_ctrl`

## Requirements
- R1: After reset, every irqPending bit and every modeOut bit is 0, every rxEnable bit is 1, and brdyIrq is 0.
- R2: When a pipe's effective mode is 0, pktDone with pktPipe = p sets irqPending[p] at the next clock edge, whatever the value of pktIsRx (1 = receive, 0 = transmit).
- R3: Only pipes MODE_PIPE_LO..MODE_PIPE_HI (default 1 to 5) hold a mode. A mode write to any other pipe leaves its modeOut bit at 0, and that pipe always behaves as mode 0.
- R4: For a pipe in mode 1, a received packet (pktDone, pktIsRx = 1) does not set irqPending. A later cpuReadLast with curPipe = p sets irqPending[p] at the next edge. A cpuReadLast with no received packet waiting has no effect.
- R5: In mode 1, rxEnable[p] falls at the same edge at which that read sets irqPending[p]. It stays low until bclrWr with ctlPipe = p, and rises at the edge that samples that write. If the write coincides with the read that closes the lock, the lock wins.
- R6: For a pipe in mode 1, a transmitted packet (pktIsRx = 0) never sets irqPending.
- R7: modeWr with ctlPipe = p loads modeWdata into modeOut[p] at the next edge only if all of these hold: ctrlStage = 0, pipeNak[p] = 1, curPipe is not p, and either pipeBusy[p] = 0 or nakByHw[p] = 1. Otherwise the write is ignored.
- R8: aclrm with ctlPipe = p clears irqPending[p] and the read-wait state and sets rxEnable[p] to 1 at the next edge. It overrides any set in the same cycle and leaves modeOut unchanged.
- R9: irqClrWr clears every irqPending bit that is 1 in irqClrMask. A set for the same pipe in the same cycle wins over the clear.
- R10: brdyIrq is 1 exactly when any irqPending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pktDone | input | 1 | A packet finished on the bus |
| pktPipe | input | PW | Pipe of the finished packet |
| pktIsRx | input | 1 | 1 = received, 0 = transmitted |
| cpuReadLast | input | 1 | CPU read the final word of a packet |
| curPipe | input | PW | Pipe selected on the CPU FIFO port |
| ctlPipe | input | PW | Target pipe of the control strobes |
| bclrWr | input | 1 | Buffer clear, re-opens reception |
| aclrm | input | 1 | Auto-clear flush strobe |
| modeWr | input | 1 | Mode write strobe |
| modeWdata | input | 1 | Mode value to write |
| ctrlStage | input | 1 | Control-transfer stage active |
| pipeNak | input | NUM_PIPES | Pipe response is NAK |
| pipeBusy | input | NUM_PIPES | Pipe still busy on the bus |
| nakByHw | input | NUM_PIPES | NAK was forced by hardware |
| irqClrWr | input | 1 | Write-1-to-clear strobe for pending flags |
| irqClrMask | input | NUM_PIPES | Pending bits to clear |
| irqPending | output | NUM_PIPES | Sticky per-pipe ready flags |
| rxEnable | output | NUM_PIPES | Reception allowed per pipe |
| modeOut | output | NUM_PIPES | Effective per-pipe mode |
| brdyIrq | output | 1 | Combined interrupt |

## Verification
The bench targets the guard on mode writes: control stage, a pipe that is not NAK, the selected pipe, and the busy flag with and without a hardware NAK. A design that gets this wrong changes mode mid-transfer or refuses a legal write. It checks that a read with no packet waiting raises nothing, and that a mode-1 transmit stays silent; a wrong design raises spurious interrupts. It checks that the lock and the interrupt appear at the same edge, and that a buffer clear colliding with the closing read leaves the pipe locked. Flush and pending-clear collisions are covered too: a wrong design would lose a fresh event, or leave a flushed pipe locked.

// File: rtl/brdy_irq_pkg.sv
package brdy_irq_pkg;
  // per-pipe strobes from control to datapath
  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic setAwait;
    logic clrAwait;
    logic setLock;
    logic clrLock;
    logic flush;
    logic modeLoad;
    logic modeVal;
  } pipeStrb_t;
endpackage

// File: rtl/brdy_irq_ctl.sv
module brdy_irq_ctl
  import brdy_irq_pkg::*;
#(
  parameter int NUM_PIPES    = 8,
  parameter int MODE_PIPE_LO = 1,
  parameter int MODE_PIPE_HI = 5,
  localparam int PW = $clog2(NUM_PIPES)
) (
  input  logic                 pktDone,
  input  logic [PW-1:0]        pktPipe,
  input  logic                 pktIsRx,
  input  logic                 cpuReadLast,
  input  logic [PW-1:0]        curPipe,
  input  logic [PW-1:0]        ctlPipe,
  input  logic                 bclrWr,
  input  logic                 aclrm,
  input  logic                 modeWr,
  input  logic                 modeWdata,
  input  logic                 ctrlStage,
  input  logic [NUM_PIPES-1:0] pipeNak,
  input  logic [NUM_PIPES-1:0] pipeBusy,
  input  logic [NUM_PIPES-1:0] nakByHw,
  input  logic                 irqClrWr,
  input  logic [NUM_PIPES-1:0] irqClrMask,
  input  logic [NUM_PIPES-1:0] modeQ,
  input  logic [NUM_PIPES-1:0] awaitQ,
  input  logic [NUM_PIPES-1:0] lockQ,
  output pipeStrb_t [NUM_PIPES-1:0] strb
);
  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic hitPkt, hitRead, hitCtl, effMode, readDone, guardOk;
    assign hitPkt  = pktDone && (pktPipe == PW'(i));
    assign hitRead = cpuReadLast && (curPipe == PW'(i));
    assign hitCtl  = (ctlPipe == PW'(i));
    assign readDone = hitRead && effMode && awaitQ[i];
    assign guardOk = !ctrlStage && pipeNak[i] && (curPipe != PW'(i))
                     && (!pipeBusy[i] || nakByHw[i]);

    if (i >= MODE_PIPE_LO && i <= MODE_PIPE_HI) begin : g_honour
      assign effMode = modeQ[i];
      always_comb begin
        strb[i].modeLoad = modeWr && hitCtl && guardOk;
        strb[i].modeVal  = modeWdata;
      end
    end else begin : g_fixed
      assign effMode = 1'b0;
      always_comb begin
        strb[i].modeLoad = 1'b0;
        strb[i].modeVal  = 1'b0;
      end
    end

    always_comb begin
      strb[i].setPend  = (hitPkt && !effMode) || readDone;
      strb[i].clrPend  = irqClrWr && irqClrMask[i];
      strb[i].setAwait = hitPkt && pktIsRx && effMode && !lockQ[i];
      strb[i].clrAwait = readDone;
      strb[i].setLock  = readDone;
      strb[i].clrLock  = bclrWr && hitCtl;
      strb[i].flush    = aclrm && hitCtl;
    end
  end
endmodule

// File: rtl/brdy_irq_dp.sv
module brdy_irq_dp
  import brdy_irq_pkg::*;
#(
  parameter int NUM_PIPES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  pipeStrb_t [NUM_PIPES-1:0] strb,
  output logic [NUM_PIPES-1:0]      pendQ,
  output logic [NUM_PIPES-1:0]      awaitQ,
  output logic [NUM_PIPES-1:0]      lockQ,
  output logic [NUM_PIPES-1:0]      modeQ
);
  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic pendR, awaitR, lockR, modeR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendR  <= 1'b0;
        awaitR <= 1'b0;
        lockR  <= 1'b0;
      end else if (strb[i].flush) begin
        pendR  <= 1'b0;
        awaitR <= 1'b0;
        lockR  <= 1'b0;
      end else begin
        if (strb[i].setPend)       pendR <= 1'b1;
        else if (strb[i].clrPend)  pendR <= 1'b0;
        if (strb[i].clrAwait)      awaitR <= 1'b0;
        else if (strb[i].setAwait) awaitR <= 1'b1;
        if (strb[i].setLock)       lockR <= 1'b1;
        else if (strb[i].clrLock)  lockR <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                modeR <= 1'b0;
      else if (strb[i].modeLoad) modeR <= strb[i].modeVal;
    end

    assign pendQ[i]  = pendR;
    assign awaitQ[i] = awaitR;
    assign lockQ[i]  = lockR;
    assign modeQ[i]  = modeR;
  end
endmodule

// File: rtl/brdy_irq_ctrl.sv
module brdy_irq_ctrl
  import brdy_irq_pkg::*;
#(
  parameter int NUM_PIPES    = 8,
  parameter int MODE_PIPE_LO = 1,
  parameter int MODE_PIPE_HI = 5,
  localparam int PW = $clog2(NUM_PIPES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pktDone,
  input  logic [PW-1:0]        pktPipe,
  input  logic                 pktIsRx,
  input  logic                 cpuReadLast,
  input  logic [PW-1:0]        curPipe,
  input  logic [PW-1:0]        ctlPipe,
  input  logic                 bclrWr,
  input  logic                 aclrm,
  input  logic                 modeWr,
  input  logic                 modeWdata,
  input  logic                 ctrlStage,
  input  logic [NUM_PIPES-1:0] pipeNak,
  input  logic [NUM_PIPES-1:0] pipeBusy,
  input  logic [NUM_PIPES-1:0] nakByHw,
  input  logic                 irqClrWr,
  input  logic [NUM_PIPES-1:0] irqClrMask,
  output logic [NUM_PIPES-1:0] irqPending,
  output logic [NUM_PIPES-1:0] rxEnable,
  output logic [NUM_PIPES-1:0] modeOut,
  output logic                 brdyIrq
);
  pipeStrb_t [NUM_PIPES-1:0] strb;
  logic [NUM_PIPES-1:0] pendQ, awaitQ, lockQ, modeQ;

  brdy_irq_ctl #(
    .NUM_PIPES(NUM_PIPES), .MODE_PIPE_LO(MODE_PIPE_LO), .MODE_PIPE_HI(MODE_PIPE_HI)
  ) u_ctl (
    .pktDone(pktDone), .pktPipe(pktPipe), .pktIsRx(pktIsRx),
    .cpuReadLast(cpuReadLast), .curPipe(curPipe), .ctlPipe(ctlPipe),
    .bclrWr(bclrWr), .aclrm(aclrm), .modeWr(modeWr), .modeWdata(modeWdata),
    .ctrlStage(ctrlStage), .pipeNak(pipeNak), .pipeBusy(pipeBusy),
    .nakByHw(nakByHw), .irqClrWr(irqClrWr), .irqClrMask(irqClrMask),
    .modeQ(modeQ), .awaitQ(awaitQ), .lockQ(lockQ), .strb(strb)
  );

  brdy_irq_dp #(.NUM_PIPES(NUM_PIPES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .pendQ(pendQ), .awaitQ(awaitQ), .lockQ(lockQ), .modeQ(modeQ)
  );

  assign irqPending = pendQ;
  assign rxEnable   = ~lockQ;
  assign modeOut    = modeQ;
  assign brdyIrq    = |pendQ;
endmodule

// File: rtl/brdy_irq_chk.sv
module brdy_irq_chk #(
  parameter int NUM_PIPES = 8,
  localparam int PW = $clog2(NUM_PIPES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pktDone,
  input logic [PW-1:0]        pktPipe,
  input logic                 cpuReadLast,
  input logic [PW-1:0]        curPipe,
  input logic [PW-1:0]        ctlPipe,
  input logic                 bclrWr,
  input logic                 aclrm,
  input logic                 modeWr,
  input logic                 ctrlStage,
  input logic [NUM_PIPES-1:0] irqPending,
  input logic [NUM_PIPES-1:0] rxEnable,
  input logic [NUM_PIPES-1:0] modeOut
);
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !modeWr |=> $stable(modeOut)); // R7
  AST_MODE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (modeWr && ctrlStage) |=> $stable(modeOut)); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    aclrm |=> (!irqPending[$past(ctlPipe)] && rxEnable[$past(ctlPipe)])); // R8

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    AST_RX_DROP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rxEnable[i]) |-> irqPending[i]); // R5
    AST_RX_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxEnable[i]) |-> $past((bclrWr || aclrm) && (ctlPipe == PW'(i)))); // R5
    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irqPending[i]) |-> $past((pktDone && (pktPipe == PW'(i)))
                                     || (cpuReadLast && (curPipe == PW'(i))))); // R4
  end
endmodule

bind brdy_irq_ctrl brdy_irq_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pktDone(pktDone), .pktPipe(pktPipe),
  .cpuReadLast(cpuReadLast), .curPipe(curPipe), .ctlPipe(ctlPipe),
  .bclrWr(bclrWr), .aclrm(aclrm), .modeWr(modeWr), .ctrlStage(ctrlStage),
  .irqPending(irqPending), .rxEnable(rxEnable), .modeOut(modeOut)
);

// File: tb/brdy_irq_ctrl_bench.sv
module brdy_irq_ctrl_bench;
  localparam int NP = 8;
  localparam int PW = 3;
  localparam int LO = 1;
  localparam int HI = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pktDone, pktIsRx, cpuReadLast, bclrWr, aclrm, modeWr, modeWdata, ctrlStage, irqClrWr;
  logic [PW-1:0] pktPipe, curPipe, ctlPipe;
  logic [NP-1:0] pipeNak, pipeBusy, nakByHw, irqClrMask;
  logic [NP-1:0] irqPending, rxEnable, modeOut;
  logic brdyIrq;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [NP-1:0] mPend, mAwait, mLock, mMode;

  always #5 clk = ~clk;

  brdy_irq_ctrl u_brdy_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pktDone(pktDone), .pktPipe(pktPipe), .pktIsRx(pktIsRx),
    .cpuReadLast(cpuReadLast), .curPipe(curPipe), .ctlPipe(ctlPipe), .bclrWr(bclrWr),
    .aclrm(aclrm), .modeWr(modeWr), .modeWdata(modeWdata), .ctrlStage(ctrlStage),
    .pipeNak(pipeNak), .pipeBusy(pipeBusy), .nakByHw(nakByHw), .irqClrWr(irqClrWr),
    .irqClrMask(irqClrMask), .irqPending(irqPending), .rxEnable(rxEnable),
    .modeOut(modeOut), .brdyIrq(brdyIrq)
  );

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    pktDone = 0; pktIsRx = 0; cpuReadLast = 0; bclrWr = 0; aclrm = 0;
    modeWr = 0; modeWdata = 0; ctrlStage = 0; irqClrWr = 0; irqClrMask = '0;
    pktPipe = '0; ctlPipe = '0;
  endtask

  // expected next state from the requirements
  task automatic modelStep();
    logic [NP-1:0] nP, nA, nL, nM;
    nP = mPend; nA = mAwait; nL = mLock; nM = mMode;
    for (int i = 0; i < NP; i++) begin
      bit hon, eff, hitPkt, hitRead, hitCtl, rd, guard;
      hon = (i >= LO) && (i <= HI);
      eff = hon && mMode[i];
      hitPkt = pktDone && (pktPipe == PW'(i));
      hitRead = cpuReadLast && (curPipe == PW'(i));
      hitCtl = (ctlPipe == PW'(i));
      rd = hitRead && eff && mAwait[i];
      guard = !ctrlStage && pipeNak[i] && (curPipe != PW'(i)) && (!pipeBusy[i] || nakByHw[i]);
      if (aclrm && hitCtl) begin
        nP[i] = 0; nA[i] = 0; nL[i] = 0;
      end else begin
        if ((hitPkt && !eff) || rd) nP[i] = 1;
        else if (irqClrWr && irqClrMask[i]) nP[i] = 0;
        if (rd) nA[i] = 0;
        else if (hitPkt && pktIsRx && eff && !mLock[i]) nA[i] = 1;
        if (rd) nL[i] = 1;
        else if (bclrWr && hitCtl) nL[i] = 0;
      end
      if (hon && modeWr && hitCtl && guard) nM[i] = modeWdata;
    end
    mPend = nP; mAwait = nA; mLock = nL; mMode = nM;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check("R2 irqPending", irqPending, mPend);
    check("R5 rxEnable", rxEnable, ~mLock);
    check("R7 modeOut", modeOut, mMode);
    check("R10 brdyIrq", {7'd0, brdyIrq}, {7'd0, |mPend});
    idle();
  endtask

  task automatic setMode(int p, bit v);
    modeWr = 1; ctlPipe = PW'(p); modeWdata = v; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    idle();
    curPipe = '0; pipeNak = '1; pipeBusy = '0; nakByHw = '0;
    mPend = '0; mAwait = '0; mLock = '0; mMode = '0;
    repeat (3) @(negedge clk);
    check("R1 irqPending", irqPending, '0);
    check("R1 rxEnable", rxEnable, '1);
    check("R1 modeOut", modeOut, '0);
    check("R1 brdyIrq", {7'd0, brdyIrq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: mode 0 tx and rx
    pktDone = 1; pktPipe = 2; pktIsRx = 0; tick();
    check("R2 tx sets pending", irqPending[2], 1'b1);
    irqClrWr = 1; irqClrMask = 8'h04; tick();
    check("R9 w1c", irqPending[2], 1'b0);
    pktDone = 1; pktPipe = 2; pktIsRx = 1; tick();
    check("R2 rx sets pending", irqPending[2], 1'b1);
    irqClrWr = 1; irqClrMask = 8'hFF; tick();

    // R7: guarded mode writes
    setMode(3, 1);
    check("R7 accepted", modeOut[3], 1'b1);
    ctrlStage = 1; setMode(4, 1);
    check("R7 ctrl stage blocks", modeOut[4], 1'b0);
    pipeNak[4] = 0; setMode(4, 1); pipeNak[4] = 1;
    check("R7 not NAK blocks", modeOut[4], 1'b0);
    pipeBusy[4] = 1; setMode(4, 1);
    check("R7 busy blocks", modeOut[4], 1'b0);
    nakByHw[4] = 1; setMode(4, 1);
    check("R7 hw NAK skips busy", modeOut[4], 1'b1);
    pipeBusy = '0; nakByHw = '0;
    curPipe = 4; setMode(4, 0); curPipe = 0;
    check("R7 selected pipe blocks", modeOut[4], 1'b1);

    // R3: pipes outside the range
    setMode(0, 1); setMode(6, 1);
    check("R3 pipe0 mode", modeOut[0], 1'b0);
    check("R3 pipe6 mode", modeOut[6], 1'b0);
    pktDone = 1; pktPipe = 6; pktIsRx = 1; tick();
    check("R3 pipe6 acts mode0", irqPending[6], 1'b1);
    irqClrWr = 1; irqClrMask = 8'hFF; tick();

    // R4/R5: mode-1 receive on pipe 3
    curPipe = 3; cpuReadLast = 1; tick();
    check("R4 read without packet", irqPending[3], 1'b0);
    pktDone = 1; pktPipe = 3; pktIsRx = 1; tick();
    check("R4 rx no irq", irqPending[3], 1'b0);
    check("R4 rx still enabled", rxEnable[3], 1'b1);
    cpuReadLast = 1; tick();
    check("R4 irq after read", irqPending[3], 1'b1);
    check("R5 lock with irq", rxEnable[3], 1'b0);
    cpuReadLast = 1; tick();
    check("R5 stays locked", rxEnable[3], 1'b0);
    bclrWr = 1; ctlPipe = 3; tick();
    check("R5 unlock after bclr", rxEnable[3], 1'b1);
    irqClrWr = 1; irqClrMask = 8'h08; tick();

    // R5 collision: bclr with closing read
    pktDone = 1; pktPipe = 3; pktIsRx = 1; tick();
    cpuReadLast = 1; bclrWr = 1; ctlPipe = 3; tick();
    check("R5 lock wins over bclr", rxEnable[3], 1'b0);
    bclrWr = 1; ctlPipe = 3; irqClrWr = 1; irqClrMask = 8'h08; tick();

    // R6: mode-1 transmit is silent
    pktDone = 1; pktPipe = 3; pktIsRx = 0; tick();
    check("R6 tx no irq", irqPending[3], 1'b0);

    // R8: flush on pipe 4 (mode 1) with coincident set
    curPipe = 4;
    pktDone = 1; pktPipe = 4; pktIsRx = 1; tick();
    cpuReadLast = 1; tick();
    check("R5 pipe4 locked", rxEnable[4], 1'b0);
    aclrm = 1; ctlPipe = 4; pktDone = 1; pktPipe = 4; pktIsRx = 1; tick();
    check("R8 pending cleared", irqPending[4], 1'b0);
    check("R8 rx reopened", rxEnable[4], 1'b1);
    check("R8 mode kept", modeOut[4], 1'b1);
    cpuReadLast = 1; tick();
    check("R8 await cleared", irqPending[4], 1'b0);

    // R9: set wins over clear
    curPipe = 0;
    pktDone = 1; pktPipe = 1; irqClrWr = 1; irqClrMask = 8'h02; tick();
    check("R9 set beats clear", irqPending[1], 1'b1);
    check("R10 or", {7'd0, brdyIrq}, 8'd1);

    // random traffic against the model
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      pktDone = ($urandom % 3) == 0; pktPipe = PW'($urandom); pktIsRx = $urandom % 2;
      cpuReadLast = ($urandom % 3) == 0; curPipe = PW'($urandom);
      ctlPipe = PW'($urandom);
      bclrWr = ($urandom % 5) == 0; aclrm = ($urandom % 11) == 0;
      modeWr = ($urandom % 4) == 0; modeWdata = $urandom % 2;
      ctrlStage = ($urandom % 4) == 0;
      pipeNak = NP'($urandom | $urandom); pipeBusy = NP'($urandom & $urandom);
      nakByHw = NP'($urandom);
      irqClrWr = ($urandom % 4) == 0; irqClrMask = NP'($urandom);
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule